// File: doc/BRIEF.md
# Four-Phase Parallel 2-Bit Lag Correlator

This block correlates two streams of 2-bit quantized samples that arrive already demultiplexed, four samples per clock on each input, packed into one byte. Every lag owns one signed accumulator. Each clock, that accumulator absorbs the combined total of the four phase products for its lag. The correlation logic therefore runs at a quarter of the sample rate. The lag array is made of repeated four-lag slices. The sample history of the Y input is shared by all slices, and a copy of it, delayed by the full span of lags, is brought out so that a second instance can extend the lag range. To get an auto-correlation, drive the same stream into both inputs.

A host starts an integration with a one-cycle strobe and gives its length in clocks. When the last integrated clock has been absorbed, every lag sum moves into a holding bank and its accumulator clears in the same edge. A one-cycle done flag then rises. The host reads any lag from the bank by address while the next integration runs.

Top module: `lagcorr_top`

## Requirements
- R1: Within a packed word, sample k sits in bits [2k+1:2k], and k=0 is the earliest of the four. Codes 0, 1, 2 and 3 stand for the levels -3, -1, +1 and +3, and each product is the signed product of the two levels.
- R2: After an integration, lag j (0 to NLAGS-1) holds the sum over every integrated X sample i of x[i]·y[i-j]. The Y samples may come from clocks before the start strobe. Y samples from before reset count as code 0.
- R3: A strobe seen while idle makes its own clock the first integrated clock. The integration then covers int_len clocks, with int_len sampled on the strobe, and a length of 0 counts as 1.
- R4: done is high for exactly the one clock after the last integrated clock, and is low at all other times.
- R5: The bank presents the new results from the cycle in which done is high. It keeps them, unchanged, until the next integration completes. rd_data follows rd_addr in the same cycle.
- R6: A start strobe that arrives during an integration, other than in its final clock, is ignored. It changes neither the length nor the results.
- R7: A start strobe in the final clock of an integration begins a new one on the very next clock, with int_len sampled again and the accumulators starting from zero.
- R8: y_casc equals y_word as it was NLAGS/4 clocks earlier, and is 0 for clocks before reset.
- R9: After reset, done is low, the block is idle and every bank entry reads 0.
- R10: With both inputs fed the same stream, lag 0 equals the sum of the squared levels of the integrated samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one packed word per input per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| x_word | input | 8 | Four X samples, earliest in bits 1:0 |
| y_word | input | 8 | Four Y samples, earliest in bits 1:0 |
| start | input | 1 | One-cycle strobe that opens an integration |
| int_len | input | LEN_W | Integration length in clocks, sampled on start |
| rd_addr | input | log2(NLAGS) | Lag index to read from the bank |
| rd_data | output | ACC_W | Signed result of the addressed lag |
| done | output | 1 | One-cycle flag: new results are in the bank |
| y_casc | output | 8 | Y word delayed NLAGS/4 clocks, for cascading |

## Verification
The clock that carries the start strobe is integrated. done and the new bank contents appear right after the edge of the int_len-th integrated clock. The bench therefore samples done at the falling edge after every rising edge, and expects it high only after that exact edge. y_casc is compared after every edge against the word recorded NLAGS/4 edges before. Bank reads are combinational: the bench sets rd_addr at a falling edge and compares rd_data at the next falling edge against a serial-sum model built from its own record of every word it drove.

// File: rtl/lagcorr_pkg.sv
package lagcorr_pkg;

  // 2-bit code to odd signed level: 0,1,2,3 -> -3,-1,+1,+3
  function automatic logic signed [3:0] level_of(input logic [1:0] code);
    return $signed({1'b0, code, 1'b0}) - 4'sd3;
  endfunction

  // signed product of two coded samples, range -9..+9
  function automatic logic signed [4:0] code_prod(input logic [1:0] a,
                                                  input logic [1:0] b);
    logic signed [7:0] p;
    p = level_of(a) * level_of(b);
    return p[4:0];
  endfunction

  // four phase products of one lag; X phase k meets window sample 3-k
  function automatic logic signed [6:0] quad_sum(input logic [7:0] xw,
                                                 input logic [7:0] yw);
    logic signed [6:0] s;
    logic signed [4:0] p;
    s = '0;
    for (int k = 0; k < 4; k++) begin
      p = code_prod(xw[2*k +: 2], yw[2*(3-k) +: 2]);
      s = s + {{2{p[4]}}, p};
    end
    return s;
  endfunction

endpackage

// File: rtl/lagcorr_cell.sv
module lagcorr_cell
  import lagcorr_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    last,
  input  logic [7:0]              x_word,
  input  logic [7:0]              ywin,
  output logic signed [ACC_W-1:0] bank_o
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [6:0]       step;
  logic signed [ACC_W-1:0] sum;

  assign step = quad_sum(x_word, ywin);
  assign sum  = acc_q + {{(ACC_W-7){step[6]}}, step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      bank_o <= '0;
    end else if (en) begin
      if (last) begin
        bank_o <= sum;
        acc_q  <= '0;
      end else begin
        acc_q  <= sum;
      end
    end
  end
endmodule

// File: rtl/lagcorr_slice.sv
module lagcorr_slice #(
  parameter int ACC_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 last,
  input  logic [7:0]           x_word,
  input  logic [13:0]          ywin7,
  output logic [4*ACC_W-1:0]   bank_o
);
  // four lags; lag l of the slice uses back samples l..l+3 of the window
  for (genvar l = 0; l < 4; l++) begin : g_lag
    logic signed [ACC_W-1:0] one;
    lagcorr_cell #(.ACC_W(ACC_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .last   (last),
      .x_word (x_word),
      .ywin   (ywin7[2*l +: 8]),
      .bank_o (one)
    );
    assign bank_o[l*ACC_W +: ACC_W] = one;
  end
endmodule

// File: rtl/lagcorr_ydelay.sv
module lagcorr_ydelay #(
  parameter int NLAGS = 64,
  localparam int DEPTH = NLAGS/4 + 1,
  localparam int NBACK = NLAGS + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         y_word,
  output logic [2*NBACK-1:0] yback,
  output logic [7:0]         y_casc
);
  logic [7:0] words [DEPTH];

  assign words[0] = y_word;

  for (genvar w = 1; w < DEPTH; w++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) words[w] <= '0;
      else        words[w] <= words[w-1];
    end
  end

  // back sample b counts backwards from the newest sample of the current word
  for (genvar b = 0; b < NBACK; b++) begin : g_back
    assign yback[2*b +: 2] = words[b/4][2*(3 - b%4) +: 2];
  end

  assign y_casc = words[DEPTH-1];
endmodule

// File: rtl/lagcorr_ctrl.sv
module lagcorr_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] int_len,
  output logic             en,
  output logic             last,
  output logic             busy,
  output logic             done
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] eff_len;

  assign eff_len = (int_len == '0) ? LEN_W'(1) : int_len;
  assign en      = busy | start;
  assign last    = busy ? (cnt_q == LEN_W'(1)) : (eff_len == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (en && last) begin
      done  <= 1'b1;
      busy  <= busy & start;
      cnt_q <= eff_len;
    end else if (en) begin
      done  <= 1'b0;
      busy  <= 1'b1;
      cnt_q <= busy ? cnt_q - LEN_W'(1) : eff_len - LEN_W'(1);
    end else begin
      done  <= 1'b0;
    end
  end
endmodule

// File: rtl/lagcorr_top.sv
module lagcorr_top #(
  parameter int NLAGS = 64,
  parameter int ACC_W = 24,
  parameter int LEN_W = 16,
  localparam int ADDR_W = $clog2(NLAGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              x_word,
  input  logic [7:0]              y_word,
  input  logic                    start,
  input  logic [LEN_W-1:0]        int_len,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic signed [ACC_W-1:0] rd_data,
  output logic                    done,
  output logic [7:0]              y_casc
);
  localparam int NSLICE = NLAGS / 4;
  localparam int NBACK  = NLAGS + 3;

  logic                     en;
  logic                     last_cyc;
  logic                     busy;
  logic                     fin_evt;
  logic [2*NBACK-1:0]       yback;
  logic [NLAGS*ACC_W-1:0]   bank_flat;
  logic signed [ACC_W-1:0]  bank_arr [NLAGS];

  lagcorr_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .int_len (int_len),
    .en      (en),
    .last    (last_cyc),
    .busy    (busy),
    .done    (done)
  );

  assign fin_evt = en & last_cyc;

  lagcorr_ydelay #(.NLAGS(NLAGS)) u_ydly (
    .clk    (clk),
    .rst_n  (rst_n),
    .y_word (y_word),
    .yback  (yback),
    .y_casc (y_casc)
  );

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    lagcorr_slice #(.ACC_W(ACC_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .last   (last_cyc),
      .x_word (x_word),
      .ywin7  (yback[2*4*s +: 14]),
      .bank_o (bank_flat[s*4*ACC_W +: 4*ACC_W])
    );
  end

  for (genvar j = 0; j < NLAGS; j++) begin : g_bank
    assign bank_arr[j] = bank_flat[j*ACC_W +: ACC_W];
  end

  assign rd_data = bank_arr[rd_addr];
endmodule

// File: rtl/lagcorr_chk.sv
module lagcorr_chk #(
  parameter int NLAGS = 64,
  parameter int ACC_W = 24,
  localparam int ADDR_W = $clog2(NLAGS),
  localparam int DLY = NLAGS / 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              busy,
  input logic              fin_evt,
  input logic [7:0]        y_word,
  input logic [7:0]        y_casc,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ACC_W-1:0]  rd_data
);
  // independent delay line for the cascade output
  logic [7:0] ref_dl [DLY];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY; i++) ref_dl[i] <= '0;
    end else begin
      ref_dl[0] <= y_word;
      for (int i = 1; i < DLY; i++) ref_dl[i] <= ref_dl[i-1];
    end
  end

  a_r8_casc_delay: assert property (@(posedge clk) disable iff (!rst_n)
    y_casc == ref_dl[DLY-1]);

  a_r4_done_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy || start));

  a_r9_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !done);

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_evt) |=> busy);

  a_r7_rearm_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && busy && start) |=> busy);

  a_r5_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_evt |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data)));
endmodule

bind lagcorr_top lagcorr_chk #(.NLAGS(NLAGS), .ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .done    (done),
  .busy    (busy),
  .fin_evt (fin_evt),
  .y_word  (y_word),
  .y_casc  (y_casc),
  .rd_addr (rd_addr),
  .rd_data (rd_data)
);

// File: tb/lagcorr_top_tb.sv
module lagcorr_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NLAGS = 64;
  localparam int DLY   = NLAGS / 4;
  localparam int HMAX  = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  x_word = '0, y_word = '0;
  logic        start = 1'b0;
  logic [15:0] int_len = '0;
  logic [5:0]  rd_addr = '0;
  logic signed [23:0] rd_data;
  logic        done;
  logic [7:0]  y_casc;

  always #(CLK_PERIOD/2) clk = ~clk;

  lagcorr_top u_dut (
    .clk(clk), .rst_n(rst_n), .x_word(x_word), .y_word(y_word),
    .start(start), .int_len(int_len), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .y_casc(y_casc)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [7:0] xh [HMAX];
  logic [7:0] yh [HMAX];
  logic exp_done = 1'b0;
  bit   in_run = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int lvl(input int code);
    return 2*code - 3;
  endfunction

  function automatic int ycode(input int idx);
    if (idx < 0) return 0;
    return (yh[idx/4] >> (2*(idx%4))) & 3;
  endfunction

  // serial sum over clocks c0..c1: x[i]*y[i-j]
  function automatic int model(input int j, input int c0, input int c1);
    int s = 0;
    for (int c = c0; c <= c1; c++)
      for (int k = 0; k < 4; k++)
        s += lvl((xh[c] >> (2*k)) & 3) * lvl(ycode(4*c + k - j));
    return s;
  endfunction

  // one clock: record driven words, then check done (R4) and y_casc (R8)
  task automatic tick();
    @(posedge clk);
    xh[cyc] = x_word;
    yh[cyc] = y_word;
    cyc++;
    @(negedge clk);
    check(done == exp_done, "R4 done timing", int'(done), int'(exp_done));
    check(y_casc == ((cyc - DLY >= 0) ? yh[cyc-DLY] : 8'h00),
          "R8 cascade", int'(y_casc), (cyc - DLY >= 0) ? int'(yh[cyc-DLY]) : 0);
  endtask

  task automatic rnd_words(input int mode, input logic [7:0] xc, input logic [7:0] yc);
    if (mode == 0) begin x_word = 8'($urandom); y_word = 8'($urandom); end
    else if (mode == 1) begin x_word = 8'($urandom); y_word = x_word; end
    else begin x_word = xc; y_word = yc; end
  endtask

  task automatic integrate(input int len, input int mode, input logic [7:0] xc,
                           input logic [7:0] yc, output int c0);
    int eff = (len == 0) ? 1 : len;
    c0 = cyc;
    for (int m = 0; m < eff; m++) begin
      rnd_words(mode, xc, yc);
      start = (m == 0);
      int_len = 16'(len);
      exp_done = (m == eff - 1);
      tick();
    end
    start = 1'b0;
    exp_done = 1'b0;
  endtask

  task automatic read_all(input int c0, input int c1, input string req);
    for (int j = 0; j < NLAGS; j++) begin
      rnd_words(0, 8'h00, 8'h00);
      rd_addr = 6'(j);
      tick();
      check(int'(rd_data) == model(j, c0, c1), req, int'(rd_data), model(j, c0, c1));
    end
  endtask

  task automatic idle(input int n, input int mode, input logic [7:0] xc, input logic [7:0] yc);
    for (int i = 0; i < n; i++) begin
      rnd_words(mode, xc, yc);
      tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (in_run) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int c0, c1;
    in_run = 1'b1;
    void'($urandom(32'd20231104));
    for (int i = 0; i < HMAX; i++) begin xh[i] = '0; yh[i] = '0; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    check(done == 1'b0, "R9 done after reset", int'(done), 0);
    check(y_casc == 8'h00, "R9 casc after reset", int'(y_casc), 0);
    rd_addr = 6'd0;  #1;
    check(rd_data == 0, "R9 bank lag0", int'(rd_data), 0);
    rd_addr = 6'd63; #1;
    check(rd_data == 0, "R9 bank lag63", int'(rd_data), 0);

    // R2/R3: random cross-correlation, short window
    idle(20, 0, 8'h00, 8'h00);
    integrate(7, 0, 8'h00, 8'h00, c0);
    read_all(c0, c0 + 6, "R2 cross len7");

    // R1: constant patterns with known levels
    idle(DLY + 2, 2, 8'hFF, 8'h00);
    integrate(3, 2, 8'hFF, 8'h00, c0);
    for (int j = 0; j < NLAGS; j += 21) begin
      rd_addr = 6'(j); tick();
      check(int'(rd_data) == -108, "R1 +3 times -3", int'(rd_data), -108);
    end
    idle(DLY + 2, 2, 8'hAA, 8'h55);
    integrate(2, 2, 8'hAA, 8'h55, c0);
    rd_addr = 6'd63; tick();
    check(int'(rd_data) == -8, "R1 +1 times -1", int'(rd_data), -8);

    // R10: auto-correlation, lag 0 is the sum of squares
    idle(5, 1, 8'h00, 8'h00);
    integrate(50, 1, 8'h00, 8'h00, c0);
    begin
      int sq = 0;
      for (int c = c0; c < c0 + 50; c++)
        for (int k = 0; k < 4; k++) sq += lvl((xh[c] >> (2*k)) & 3) ** 2;
      rd_addr = 6'd0; tick();
      check(int'(rd_data) == sq, "R10 auto lag0", int'(rd_data), sq);
    end
    read_all(c0, c0 + 49, "R2 auto len50");

    // R3: length zero counts as one
    idle(4, 0, 8'h00, 8'h00);
    integrate(0, 0, 8'h00, 8'h00, c0);
    read_all(c0, c0, "R3 len0");

    // R6: extra strobe mid-integration ignored
    idle(4, 0, 8'h00, 8'h00);
    c0 = cyc;
    for (int m = 0; m < 10; m++) begin
      rnd_words(0, 8'h00, 8'h00);
      start = (m == 0) || (m == 4);
      int_len = (m == 4) ? 16'd3 : 16'd10;
      exp_done = (m == 9);
      tick();
    end
    start = 1'b0; exp_done = 1'b0;
    read_all(c0, c0 + 9, "R6 busy strobe");

    // R7 + R5: re-arm in final clock, old bank held during second run
    idle(4, 0, 8'h00, 8'h00);
    c0 = cyc;
    for (int m = 0; m < 11; m++) begin
      rnd_words(0, 8'h00, 8'h00);
      start = (m == 0) || (m == 4);
      int_len = (m == 4) ? 16'd6 : 16'd5;
      exp_done = (m == 4) || (m == 10);
      if (m >= 5) rd_addr = 6'(m - 5);
      tick();
      if (m >= 5 && m <= 9)
        check(int'(rd_data) == model(m - 5, c0, c0 + 4), "R5 bank held",
              int'(rd_data), model(m - 5, c0, c0 + 4));
      start = 1'b0;
    end
    exp_done = 1'b0;
    read_all(c0 + 5, c0 + 10, "R7 rearm window");

    // R2: long random window
    idle(3, 0, 8'h00, 8'h00);
    integrate(1000, 0, 8'h00, 8'h00, c0);
    c1 = c0 + 999;
    read_all(c0, c1, "R2 cross len1000");

    in_run = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule